// File: doc/BRIEF.md
# I/O Coherency Window Decoder

This block sits in front of the routing decision for transactions issued by I/O masters. For each request it checks whether the target address lies inside one configurable window of physical memory. It then answers, one cycle later, with a flag that says whether the transaction must take the coherent path. Software sets up the window through a small register port. The window size is held as a logarithmic code and the base is held in 4 KB units. The window must be naturally aligned to its own size. A combinational error flag reports a window that cannot be decoded.

Requests follow a valid/ready handshake. The block holds one registered answer and stalls new requests while that answer waits for the consumer. Partial-line (sub-line) accesses can be excluded from coherent handling through a separate enable.

Top module: `ioc_aperture_decoder`

## Requirements
- R1: After reset all four configuration registers read 0, rsp_valid is 0, req_ready is 1 and cfg_err is 0.
- R2: Size register code c (selector 0, bits [4:0]) defines a window of 2^(c+12) bytes. An address is inside when it lies in [base*4096, base*4096 + 2^(c+12)). Codes 0, 3, 0x11 (512 MB), 0x12 (1 GB) and 0x14 (the whole 32-bit space) decode this way.
- R3: The base register (selector 1, bits [19:0]) holds the window start address divided by 4096.
- R4: If the base is not a multiple of the window size, cfg_err is 1 and every response is non-coherent.
- R5: A size code above 20, which describes a window larger than the 32-bit address space, sets cfg_err and suppresses every match.
- R6: While the enable register (selector 3, bit 0) is 0, every response is non-coherent. The enable register resets to 0.
- R7: A request with req_partial=1 inside the window is coherent only when the partial enable register (selector 2, bit 0) is 1. A request with req_partial=0 is not affected by that register.
- R8: A request accepted on a clock edge (req_valid and req_ready both 1) produces rsp_valid=1 with its answer right after that edge.
- R9: While rsp_valid=1 and rsp_ready=0, req_ready is 0, and rsp_valid and rsp_coherent hold their values.
- R10: cfg_rdata returns the register selected by cfg_sel, zero extended. Written bits above each field's width are dropped.
- R11: A register write on the same edge that accepts a request does not affect that request's answer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register selector: 0 size code, 1 base, 2 partial enable, 3 enable |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data of the selected register |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_addr | input | 32 | Physical address of the request |
| req_partial | input | 1 | Request covers only part of a line |
| rsp_valid | output | 1 | Answer present |
| rsp_ready | input | 1 | Consumer takes the answer |
| rsp_coherent | output | 1 | Answer: route through the coherent path |
| cfg_err | output | 1 | Window configuration cannot be decoded |

## Verification
The hardest situations to reach are those where timing decides the answer. One is a register write on the very edge that accepts a request. The other is a stalled answer with a new request already waiting behind it. Directed sequences drive the enable write and the request in the same cycle. They also hold rsp_ready low across several cycles while a non-matching request is presented, then release it so that the old answer leaves and the new one enters on one edge. The table exercises window edges one byte inside and outside for small and large codes, plus misaligned and oversized configurations.

// File: rtl/ioc_aperture_pkg.sv
package ioc_aperture_pkg;
  localparam int UNIT_SHIFT = 12;

  typedef enum logic [1:0] {
    RSEL_SIZE = 2'd0,
    RSEL_BASE = 2'd1,
    RSEL_PART = 2'd2,
    RSEL_EN   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/ioc_aperture_regs.sv
module ioc_aperture_regs
  import ioc_aperture_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CODE_W = 5,
  parameter int BASE_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [1:0]        sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [CODE_W-1:0] size_code,
  output logic [BASE_W-1:0] base_units,
  output logic              part_en,
  output logic              enable
);
  reg_sel_e sel_e;
  assign sel_e = reg_sel_e'(sel);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      size_code  <= '0;
      base_units <= '0;
      part_en    <= 1'b0;
      enable     <= 1'b0;
    end else if (we) begin
      case (sel_e)
        RSEL_SIZE: size_code  <= wdata[CODE_W-1:0];
        RSEL_BASE: base_units <= wdata[BASE_W-1:0];
        RSEL_PART: part_en    <= wdata[0];
        RSEL_EN:   enable     <= wdata[0];
        default:   ;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    case (sel_e)
      RSEL_SIZE: rdata[CODE_W-1:0] = size_code;
      RSEL_BASE: rdata[BASE_W-1:0] = base_units;
      RSEL_PART: rdata[0]          = part_en;
      RSEL_EN:   rdata[0]          = enable;
      default:   rdata = '0;
    endcase
  end

  // R1: registers come out of reset cleared
  always_ff @(posedge clk) begin
    if (rst_n && $past(!rst_n)) begin
      AST_REGS_CLEAR: assert (size_code == '0 && base_units == '0 && !part_en && !enable); // R1
    end
  end
endmodule

// File: rtl/ioc_aperture_match.sv
module ioc_aperture_match
  import ioc_aperture_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CODE_W = 5,
  parameter int BASE_W = 20
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              partial,
  input  logic [CODE_W-1:0] size_code,
  input  logic [BASE_W-1:0] base_units,
  input  logic              part_en,
  input  logic              enable,
  output logic              oversize,
  output logic              misaligned,
  output logic              in_window,
  output logic              hit
);
  // Mask of the 4 KB unit bits that lie inside the window.
  function automatic logic [BASE_W-1:0] inner_unit_mask(input logic [CODE_W-1:0] c);
    logic [BASE_W-1:0] m;
    for (int i = 0; i < BASE_W; i++) begin
      m[i] = (i < int'(c));
    end
    return m;
  endfunction

  function automatic logic code_too_large(input logic [CODE_W-1:0] c);
    return int'(c) > BASE_W;
  endfunction

  logic [BASE_W-1:0] mask;
  logic [BASE_W-1:0] addr_units;

  assign mask       = inner_unit_mask(size_code);
  assign addr_units = addr[ADDR_W-1:UNIT_SHIFT];
  assign oversize   = code_too_large(size_code);
  assign misaligned = |(base_units & mask);
  assign in_window  = ((addr_units ^ base_units) & ~mask) == '0;
  assign hit        = enable & ~oversize & ~misaligned & in_window & (~partial | part_en);
endmodule

// File: rtl/ioc_aperture_outreg.sv
module ioc_aperture_outreg (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  output logic req_ready,
  input  logic hit,
  output logic rsp_valid,
  input  logic rsp_ready,
  output logic rsp_coherent,
  output logic accept
);
  assign req_ready = ~rsp_valid | rsp_ready;
  assign accept    = req_valid & req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_coherent <= 1'b0;
    end else if (accept) begin
      rsp_valid    <= 1'b1;
      rsp_coherent <= hit;
    end else if (rsp_ready) begin
      rsp_valid    <= 1'b0;
    end
  end

  AST_RSP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rsp_valid); // R8
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_coherent))); // R9
endmodule

// File: rtl/ioc_aperture_decoder.sv
module ioc_aperture_decoder
  import ioc_aperture_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CODE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_partial,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_coherent,
  output logic              cfg_err
);
  localparam int BASE_W = ADDR_W - UNIT_SHIFT;

  logic [CODE_W-1:0] size_code;
  logic [BASE_W-1:0] base_units;
  logic              part_en;
  logic              enable;
  logic              oversize;
  logic              misaligned;
  logic              in_window;
  logic              hit;
  logic              accept;

  ioc_aperture_regs #(.DATA_W(DATA_W), .CODE_W(CODE_W), .BASE_W(BASE_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .we         (cfg_we),
    .sel        (cfg_sel),
    .wdata      (cfg_wdata),
    .rdata      (cfg_rdata),
    .size_code  (size_code),
    .base_units (base_units),
    .part_en    (part_en),
    .enable     (enable)
  );

  ioc_aperture_match #(.ADDR_W(ADDR_W), .CODE_W(CODE_W), .BASE_W(BASE_W)) u_match (
    .addr       (req_addr),
    .partial    (req_partial),
    .size_code  (size_code),
    .base_units (base_units),
    .part_en    (part_en),
    .enable     (enable),
    .oversize   (oversize),
    .misaligned (misaligned),
    .in_window  (in_window),
    .hit        (hit)
  );

  ioc_aperture_outreg u_out (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .hit          (hit),
    .rsp_valid    (rsp_valid),
    .rsp_ready    (rsp_ready),
    .rsp_coherent (rsp_coherent),
    .accept       (accept)
  );

  assign cfg_err = oversize | misaligned;

  AST_ERR_SUPPRESS: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cfg_err) |=> !rsp_coherent); // R4
  AST_OVERSIZE_SUPPRESS: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && oversize) |=> !rsp_coherent); // R5
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !enable) |=> !rsp_coherent); // R6
  AST_PARTIAL_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_partial && !part_en) |=> !rsp_coherent); // R7
  AST_OUTSIDE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !in_window) |=> !rsp_coherent); // R2
endmodule

// File: tb/ioc_aperture_decoder_bench.sv
module ioc_aperture_decoder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        req_partial = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic        rsp_coherent;
  logic        cfg_err;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ioc_aperture_decoder u_ioc_aperture_decoder (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .req_partial(req_partial),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_coherent(rsp_coherent),
    .cfg_err(cfg_err)
  );

  typedef struct packed {
    logic [4:0]  code;
    logic [19:0] base;
    logic        pen;
    logic        en;
    logic [31:0] addr;
    logic        part;
    logic        coh;
    logic        err;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{5'h00, 20'h00010, 1'b0, 1'b1, 32'h0001_0000, 1'b0, 1'b1, 1'b0}, // R2 first byte
    '{5'h00, 20'h00010, 1'b0, 1'b1, 32'h0001_0FFF, 1'b0, 1'b1, 1'b0}, // R2 last byte
    '{5'h00, 20'h00010, 1'b0, 1'b1, 32'h0001_1000, 1'b0, 1'b0, 1'b0}, // R2 just above
    '{5'h00, 20'h00010, 1'b0, 1'b1, 32'h0000_FFFF, 1'b0, 1'b0, 1'b0}, // R2 just below
    '{5'h11, 20'h20000, 1'b0, 1'b1, 32'h3FFF_FFFF, 1'b0, 1'b1, 1'b0}, // R3 512 MB
    '{5'h11, 20'h20000, 1'b0, 1'b1, 32'h4000_0000, 1'b0, 1'b0, 1'b0}, // R3 above
    '{5'h12, 20'h40000, 1'b0, 1'b1, 32'h7FFF_FFF0, 1'b0, 1'b1, 1'b0}, // R2 1 GB
    '{5'h12, 20'h20000, 1'b0, 1'b1, 32'h2000_0000, 1'b0, 1'b0, 1'b1}, // R4 misaligned
    '{5'h15, 20'h00000, 1'b0, 1'b1, 32'h0000_0000, 1'b0, 1'b0, 1'b1}, // R5 oversize
    '{5'h14, 20'h00000, 1'b0, 1'b1, 32'hFFFF_FFFF, 1'b0, 1'b1, 1'b0}, // R2 whole space
    '{5'h00, 20'h00010, 1'b0, 1'b0, 32'h0001_0000, 1'b0, 1'b0, 1'b0}, // R6 disabled
    '{5'h00, 20'h00010, 1'b0, 1'b1, 32'h0001_0000, 1'b1, 1'b0, 1'b0}, // R7 partial blocked
    '{5'h00, 20'h00010, 1'b1, 1'b1, 32'h0001_0000, 1'b1, 1'b1, 1'b0}, // R7 partial allowed
    '{5'h03, 20'h00008, 1'b0, 1'b1, 32'h0000_FFFF, 1'b0, 1'b1, 1'b0}, // R2 32 KB
    '{5'h03, 20'h00004, 1'b0, 1'b1, 32'h0000_4000, 1'b0, 1'b0, 1'b1}, // R4 misaligned
    '{5'h03, 20'h00008, 1'b1, 1'b1, 32'h0000_8000, 1'b0, 1'b1, 1'b0}  // R7 full access
  };

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [31:0] data);
    @(negedge clk);
    cfg_sel = sel;
    #1 data = cfg_rdata;
  endtask

  task automatic send(input logic [31:0] addr, input logic part);
    @(negedge clk);
    req_valid = 1'b1; req_addr = addr; req_partial = part; rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    #1;
    chk("R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);
    chk("R1 req_ready", {31'd0, req_ready}, 32'd1);
    chk("R1 cfg_err", {31'd0, cfg_err}, 32'd0);
    for (int s = 0; s < 4; s++) begin
      rd(2'(s), v);
      chk($sformatf("R1 reg %0d", s), v, 32'd0);
    end

    // R10 readback with oversized writes
    for (int s = 0; s < 4; s++) wr(2'(s), 32'hFFFF_FFFF);
    rd(2'd0, v); chk("R10 size code", v, 32'h0000_001F);
    rd(2'd1, v); chk("R10 base", v, 32'h000F_FFFF);
    rd(2'd2, v); chk("R10 partial enable", v, 32'h1);
    rd(2'd3, v); chk("R10 enable", v, 32'h1);
    chk("R5 code 31 error", {31'd0, cfg_err}, 32'd1);

    // R2 R3 R4 R5 R6 R7 table
    for (int k = 0; k < NV; k++) begin
      wr(2'd0, {27'd0, VECS[k].code});
      wr(2'd1, {12'd0, VECS[k].base});
      wr(2'd2, {31'd0, VECS[k].pen});
      wr(2'd3, {31'd0, VECS[k].en});
      send(VECS[k].addr, VECS[k].part);
      chk($sformatf("R8 table %0d rsp_valid", k), {31'd0, rsp_valid}, 32'd1);
      chk($sformatf("R2 R3 R4 R5 R6 R7 table %0d coherent", k), {31'd0, rsp_coherent}, {31'd0, VECS[k].coh});
      chk($sformatf("R4 R5 table %0d cfg_err", k), {31'd0, cfg_err}, {31'd0, VECS[k].err});
    end
    @(negedge clk);
    chk("R8 rsp_valid drops", {31'd0, rsp_valid}, 32'd0);

    // R11 write on accept edge
    wr(2'd0, 32'h0); wr(2'd1, 32'h10); wr(2'd2, 32'h0); wr(2'd3, 32'h1);
    @(negedge clk);
    req_valid = 1'b1; req_addr = 32'h0001_0000; req_partial = 1'b0;
    cfg_we = 1'b1; cfg_sel = 2'd3; cfg_wdata = 32'h0;
    @(negedge clk);
    req_valid = 1'b0; cfg_we = 1'b0;
    chk("R11 old config used", {31'd0, rsp_coherent}, 32'd1);
    send(32'h0001_0000, 1'b0);
    chk("R6 R11 new config used", {31'd0, rsp_coherent}, 32'd0);

    // R9 backpressure
    wr(2'd3, 32'h1);
    @(negedge clk);
    rsp_ready = 1'b0; req_valid = 1'b1; req_addr = 32'h0001_0000;
    @(negedge clk);
    req_addr = 32'h0000_0000;
    for (int c = 0; c < 3; c++) begin
      chk("R9 held valid", {31'd0, rsp_valid}, 32'd1);
      chk("R9 held coherent", {31'd0, rsp_coherent}, 32'd1);
      chk("R9 ready low", {31'd0, req_ready}, 32'd0);
      @(negedge clk);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 waiting request answered", {31'd0, rsp_coherent}, 32'd0);
    chk("R8 waiting request valid", {31'd0, rsp_valid}, 32'd1);
    @(negedge clk);
    chk("R9 drained", {31'd0, rsp_valid}, 32'd0);

    done = 1'b1;
    finish_run();
  end
endmodule